// File: doc/BRIEF.md
# Segment Base Write Execution Unit

This unit executes the two instructions that load a new value into the FS or the GS segment base of a 64-bit core. The front end has already split the instruction into prefix flags, two opcode bytes and a ModRM byte. It presents them with the source register value, the current processor mode, the control-register enable bit for this feature and the capability bit. The unit applies the legality rules, sizes the operand, updates one of its two 64-bit base registers, and reports the outcome one cycle later.

The input side is a single strobe, `in_valid`. The unit has no ready signal and never pushes back: it accepts a new instruction on every clock edge, so back-to-back strobes each complete in order. The outcome appears on `done`, `fault` or `not_handled` in the cycle after the strobe. Both base values are visible on their own outputs at all times. The unit also drives the index of the source register, worked out from the ModRM byte, so that upstream logic can read the register file and return `src_val` in the same cycle.

Top module: `seg_base_wr_unit`

## Requirements
- R1: An input is handled only when `pfx_rep` is 1, `opc0` is 0x0F, `opc1` is 0xAE and ModRM bits [5:3] are 2 or 3. The value 2 selects the FS base and the value 3 selects the GS base.
- R2: Any other strobed input writes no base and raises no fault. It gives `done` = 0 and a one-cycle `not_handled` pulse in the following cycle.
- R3: `src_idx` always equals {`rex_b`, ModRM[2:0]}.
- R4: With `rex_w` = 1, the selected base receives all 64 bits of `src_val`.
- R5: With `rex_w` = 0, the selected base receives `src_val[31:0]` with its upper 32 bits cleared, whatever the upper bits of the source hold.
- R6: `cpu_mode` values 0 (real), 1 (virtual-8086), 2 (protected) and 3 (compatibility) raise the invalid-opcode fault. Only value 4 (64-bit) can complete a write.
- R7: The invalid-opcode fault is also raised when `pfx_lock` is 1, when `cr_fsgs_en` is 0, or when `cap_fsgs` is 0.
- R8: With `rex_w` = 1, a source whose bits 63 down to 47 are not all equal raises the general-protection fault. The 32-bit form never raises it.
- R9: When invalid-opcode and general-protection conditions are both present, the invalid-opcode fault is reported. A faulting instruction writes neither base.
- R10: A handled strobe sampled at a clock edge gives `done` = 1 for exactly the next cycle, with `fault` coded 0 = none, 1 = invalid opcode, 2 = general protection. Any write takes effect at that same edge. With no strobe, `done` and `not_handled` stay 0.
- R11: A successful write changes only the selected base. The other base keeps its value.
- R12: Reset clears both bases, `done`, `fault` and `not_handled` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction strobe, accepted every cycle |
| pfx_rep | input | 1 | F3 mandatory prefix present |
| pfx_lock | input | 1 | LOCK prefix present |
| rex_w | input | 1 | REX.W operand-size bit |
| rex_b | input | 1 | REX.B register-extension bit |
| opc0 | input | 8 | First opcode byte |
| opc1 | input | 8 | Second opcode byte |
| modrm | input | 8 | ModRM byte |
| src_val | input | 64 | Source register value |
| cpu_mode | input | 3 | Processor mode code |
| cr_fsgs_en | input | 1 | Control-register enable for base writes |
| cap_fsgs | input | 1 | Capability bit for base writes |
| src_idx | output | 4 | Source register index |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | Fault code for the completed instruction |
| not_handled | output | 1 | One-cycle pulse for an unmatched input |
| fs_base | output | 64 | Current FS base |
| gs_base | output | 64 | Current GS base |

## Verification
The table drives both selectors in both operand sizes. The sources are chosen so that a 32-bit write whose source has nonzero or non-canonical upper bits shows whether zero-extension happens, and shows whether the canonical check runs before or after sizing. Each gating input is turned off alone to show which one raises the invalid-opcode fault. A non-canonical source paired with a wrong mode tells the fault priority apart. Inputs that miss by one field (prefix, second opcode byte, register field 1 or 5) show that the decode compares every field. A base written earlier, followed by a faulting write to it, shows whether a fault really suppresses the write.

// File: rtl/seg_base_pkg.sv
package seg_base_pkg;
  typedef enum logic [2:0] {
    MODE_REAL   = 3'd0,
    MODE_V86    = 3'd1,
    MODE_PROT   = 3'd2,
    MODE_COMPAT = 3'd3,
    MODE_LONG   = 3'd4
  } cpu_mode_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } fault_e;

  localparam logic [7:0] OPC_ESCAPE = 8'h0F;
  localparam logic [7:0] OPC_GROUP  = 8'hAE;
  localparam logic [2:0] REGF_FS    = 3'd2;
  localparam logic [2:0] REGF_GS    = 3'd3;
  localparam int unsigned NUM_BASES = 2;
  localparam int unsigned SEL_FS    = 0;
  localparam int unsigned SEL_GS    = 1;
endpackage

// File: rtl/sbw_decode.sv
module sbw_decode
  import seg_base_pkg::*;
(
  input  logic       pfx_rep,
  input  logic [7:0] opc0,
  input  logic [7:0] opc1,
  input  logic [7:0] modrm,
  input  logic       rex_b,
  output logic       hit,
  output logic       sel_gs,
  output logic [3:0] src_idx
);
  logic [2:0] reg_fld;
  logic       opc_ok;
  logic       reg_ok;

  always_comb begin
    reg_fld = modrm[5:3];
    opc_ok  = pfx_rep && (opc0 == OPC_ESCAPE) && (opc1 == OPC_GROUP);
    reg_ok  = (reg_fld == REGF_FS) || (reg_fld == REGF_GS);
    hit     = opc_ok && reg_ok;
    sel_gs  = (reg_fld == REGF_GS);
    src_idx = {rex_b, modrm[2:0]};
  end
endmodule

// File: rtl/sbw_legality.sv
module sbw_legality
  import seg_base_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned VA_BITS = 48,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [2:0]        cpu_mode,
  input  logic              pfx_lock,
  input  logic              cr_en,
  input  logic              cap,
  input  logic              rex_w,
  input  logic [DATA_W-1:0] src_val,
  output fault_e            fault,
  output logic [DATA_W-1:0] operand
);
  localparam int unsigned TOP_W = DATA_W - VA_BITS + 1;

  logic [TOP_W-1:0] top_bits;
  logic             canonical;
  logic             ud_cond;

  always_comb begin
    if (rex_w) operand = src_val;
    else       operand = {{(DATA_W-NARROW_W){1'b0}}, src_val[NARROW_W-1:0]};

    top_bits  = operand[DATA_W-1:VA_BITS-1];
    canonical = (&top_bits) || (~|top_bits);

    ud_cond = (cpu_mode != MODE_LONG) || pfx_lock || !cr_en || !cap;

    if (ud_cond)         fault = FLT_UD;
    else if (!canonical) fault = FLT_GP;
    else                 fault = FLT_NONE;
  end
endmodule

// File: rtl/sbw_base_bank.sv
module sbw_base_bank
  import seg_base_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NUM    = NUM_BASES,
  localparam int unsigned SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM-1:0][DATA_W-1:0] bases
);
  for (genvar i = 0; i < NUM; i++) begin : g_base
    logic [DATA_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       val_q <= '0;
      else if (wr_en && (wr_sel == SEL_W'(i)))          val_q <= wr_data;
    end
    assign bases[i] = val_q;
  end
endmodule

// File: rtl/seg_base_wr_unit.sv
module seg_base_wr_unit
  import seg_base_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned VA_BITS = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              pfx_rep,
  input  logic              pfx_lock,
  input  logic              rex_w,
  input  logic              rex_b,
  input  logic [7:0]        opc0,
  input  logic [7:0]        opc1,
  input  logic [7:0]        modrm,
  input  logic [DATA_W-1:0] src_val,
  input  logic [2:0]        cpu_mode,
  input  logic              cr_fsgs_en,
  input  logic              cap_fsgs,
  output logic [3:0]        src_idx,
  output logic              done,
  output logic [1:0]        fault,
  output logic              not_handled,
  output logic [DATA_W-1:0] fs_base,
  output logic [DATA_W-1:0] gs_base
);
  logic                             hit;
  logic                             sel_gs;
  fault_e                           chk_fault;
  logic [DATA_W-1:0]                operand;
  logic                             do_write;
  logic [NUM_BASES-1:0][DATA_W-1:0] bank_out;
  logic                             done_q;
  logic                             nh_q;
  fault_e                           fault_q;

  sbw_decode u_dec (
    .pfx_rep (pfx_rep),
    .opc0    (opc0),
    .opc1    (opc1),
    .modrm   (modrm),
    .rex_b   (rex_b),
    .hit     (hit),
    .sel_gs  (sel_gs),
    .src_idx (src_idx)
  );

  sbw_legality #(.DATA_W(DATA_W), .VA_BITS(VA_BITS)) u_leg (
    .cpu_mode (cpu_mode),
    .pfx_lock (pfx_lock),
    .cr_en    (cr_fsgs_en),
    .cap      (cap_fsgs),
    .rex_w    (rex_w),
    .src_val  (src_val),
    .fault    (chk_fault),
    .operand  (operand)
  );

  assign do_write = in_valid && hit && (chk_fault == FLT_NONE);

  sbw_base_bank #(.DATA_W(DATA_W), .NUM(NUM_BASES)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (do_write),
    .wr_sel  (sel_gs),
    .wr_data (operand),
    .bases   (bank_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      nh_q    <= 1'b0;
      fault_q <= FLT_NONE;
    end else begin
      done_q  <= in_valid && hit;
      nh_q    <= in_valid && !hit;
      fault_q <= (in_valid && hit) ? chk_fault : FLT_NONE;
    end
  end

  assign done        = done_q;
  assign not_handled = nh_q;
  assign fault       = fault_q;
  assign fs_base     = bank_out[SEL_FS];
  assign gs_base     = bank_out[SEL_GS];
endmodule

// File: rtl/sbw_chk.sv
module sbw_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              done,
  input logic [1:0]        fault,
  input logic              not_handled,
  input logic [DATA_W-1:0] fs_base,
  input logic [DATA_W-1:0] gs_base
);
  // R10
  fault_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != 2'd0) |-> done);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!done && !not_handled));

  // R2
  nh_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && not_handled));

  // R2
  nh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    not_handled |-> ($stable(fs_base) && $stable(gs_base)));

  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'd0) |-> ($stable(fs_base) && $stable(gs_base)));

  // R11
  one_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($stable(fs_base) || $stable(gs_base)));

  // R10
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault != 2'd3);
endmodule

bind seg_base_wr_unit sbw_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .done        (done),
  .fault       (fault),
  .not_handled (not_handled),
  .fs_base     (fs_base),
  .gs_base     (gs_base)
);

// File: tb/seg_base_wr_unit_test.sv
module seg_base_wr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        pfx_rep = 1'b0, pfx_lock = 1'b0, rex_w = 1'b0, rex_b = 1'b0;
  logic [7:0]  opc0 = '0, opc1 = '0, modrm = '0;
  logic [63:0] src_val = '0;
  logic [2:0]  cpu_mode = 3'd4;
  logic        cr_fsgs_en = 1'b1, cap_fsgs = 1'b1;
  logic [3:0]  src_idx;
  logic        done, not_handled;
  logic [1:0]  fault;
  logic [63:0] fs_base, gs_base;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] m_fs = '0, m_gs = '0;

  always #2 clk = ~clk;

  seg_base_wr_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pfx_rep(pfx_rep),
    .pfx_lock(pfx_lock), .rex_w(rex_w), .rex_b(rex_b), .opc0(opc0),
    .opc1(opc1), .modrm(modrm), .src_val(src_val), .cpu_mode(cpu_mode),
    .cr_fsgs_en(cr_fsgs_en), .cap_fsgs(cap_fsgs), .src_idx(src_idx),
    .done(done), .fault(fault), .not_handled(not_handled),
    .fs_base(fs_base), .gs_base(gs_base)
  );

  typedef struct packed {
    logic        rep;
    logic        lock;
    logic        w;
    logic [7:0]  o0;
    logic [7:0]  o1;
    logic [7:0]  mrm;
    logic [63:0] src;
    logic [2:0]  mode;
    logic        cr;
    logic        cap;
    logic [1:0]  xflt;
    logic        xnh;
  } vec_t;

  localparam int NV = 18;
  // ModRM 0xD0 = reg 2 (FS), 0xD8 = reg 3 (GS), 0xC8 = reg 1, 0xE8 = reg 5
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hD0,64'h0000_7FFF_1234_5678,3'd4,1'b1,1'b1,2'd0,1'b0}, // R1 R4 FS
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hD8,64'hFFFF_8000_0000_0010,3'd4,1'b1,1'b1,2'd0,1'b0}, // R1 R4 GS
    '{1'b1,1'b0,1'b0,8'h0F,8'hAE,8'hD8,64'hDEAD_BEEF_CAFE_F00D,3'd4,1'b1,1'b1,2'd0,1'b0}, // R5
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hD0,64'h0000_8000_0000_0000,3'd4,1'b1,1'b1,2'd2,1'b0}, // R8 GP
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hD8,64'h7FFF_FFFF_FFFF_FFFF,3'd4,1'b1,1'b1,2'd2,1'b0}, // R8 GP
    '{1'b1,1'b0,1'b0,8'h0F,8'hAE,8'hD0,64'h8000_0000_0000_0001,3'd4,1'b1,1'b1,2'd0,1'b0}, // R8 R5 narrow passes
    '{1'b1,1'b1,1'b1,8'h0F,8'hAE,8'hD0,64'h0000_0000_0000_00AA,3'd4,1'b1,1'b1,2'd1,1'b0}, // R7 lock
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hD8,64'h0000_0000_0000_00BB,3'd4,1'b0,1'b1,2'd1,1'b0}, // R7 enable off
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hD8,64'h0000_0000_0000_00CC,3'd4,1'b1,1'b0,2'd1,1'b0}, // R7 capability off
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hD0,64'h0000_0000_0000_00DD,3'd3,1'b1,1'b1,2'd1,1'b0}, // R6 compat
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hD0,64'h0000_0000_0000_00DE,3'd2,1'b1,1'b1,2'd1,1'b0}, // R6 protected
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hD8,64'h0000_0000_0000_00DF,3'd1,1'b1,1'b1,2'd1,1'b0}, // R6 v86
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hD8,64'h0000_0000_0000_00E0,3'd0,1'b1,1'b1,2'd1,1'b0}, // R6 real
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hD0,64'h0001_0000_0000_0000,3'd3,1'b1,1'b1,2'd1,1'b0}, // R9 UD over GP
    '{1'b0,1'b0,1'b1,8'h0F,8'hAE,8'hD0,64'h1111_1111_1111_1111,3'd4,1'b1,1'b1,2'd0,1'b1}, // R2 no F3
    '{1'b1,1'b0,1'b1,8'h0F,8'hAF,8'hD8,64'h2222_2222_2222_2222,3'd4,1'b1,1'b1,2'd0,1'b1}, // R2 opcode
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hC8,64'h3333_3333_3333_3333,3'd4,1'b1,1'b1,2'd0,1'b1}, // R2 reg 1
    '{1'b1,1'b0,1'b1,8'h0F,8'hAE,8'hE8,64'h0000_0000_0000_0444,3'd4,1'b1,1'b1,2'd0,1'b1}  // R2 reg 5
  };

  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic apply(input vec_t v);
    pfx_rep = v.rep; pfx_lock = v.lock; rex_w = v.w; rex_b = 1'b0;
    opc0 = v.o0; opc1 = v.o1; modrm = v.mrm; src_val = v.src;
    cpu_mode = v.mode; cr_fsgs_en = v.cr; cap_fsgs = v.cap;
  endtask

  // Model update from the requirements
  task automatic model(input vec_t v);
    logic [63:0] val;
    if (v.xflt == 2'd0 && !v.xnh) begin
      val = v.w ? v.src : {32'h0, v.src[31:0]};
      if (v.mrm[5:3] == 3'd3) m_gs = val;
      else                    m_fs = val;
    end
  endtask

  task automatic check_outcome(input vec_t v, input int idx);
    chk(done === !v.xnh, $sformatf("R10 done v%0d", idx), {63'h0, done}, {63'h0, !v.xnh});
    chk(not_handled === v.xnh, $sformatf("R2 not_handled v%0d", idx), {63'h0, not_handled}, {63'h0, v.xnh});
    chk(fault === v.xflt, $sformatf("R10 fault code v%0d", idx), {62'h0, fault}, {62'h0, v.xflt});
    chk(fs_base === m_fs, $sformatf("R11 fs_base v%0d", idx), fs_base, m_fs);
    chk(gs_base === m_gs, $sformatf("R11 gs_base v%0d", idx), gs_base, m_gs);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk(fs_base === 64'h0, "R12 fs reset", fs_base, 64'h0);
    chk(gs_base === 64'h0, "R12 gs reset", gs_base, 64'h0);
    chk(done === 1'b0 && not_handled === 1'b0 && fault === 2'd0, "R12 flags reset",
        {61'h0, done, not_handled, |fault}, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    // R10 idle: no strobe, no outcome
    repeat (2) @(posedge clk);
    #1;
    chk(done === 1'b0 && not_handled === 1'b0, "R10 idle quiet",
        {62'h0, done, not_handled}, 64'h0);

    // Table walk, strobe held high so vectors run back to back
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      in_valid = 1'b1;
      @(posedge clk);
      #1;
      model(VECS[i]);
      check_outcome(VECS[i], i);
    end
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    chk(done === 1'b0 && not_handled === 1'b0, "R10 pulse ends",
        {62'h0, done, not_handled}, 64'h0);

    // R3 source index from REX.B and ModRM r/m
    for (int b = 0; b < 2; b++) begin
      for (int rm = 0; rm < 8; rm += 5) begin
        rex_b = b[0]; modrm = {5'b11011, rm[2:0]};
        #1;
        chk(src_idx === {b[0], rm[2:0]}, "R3 src_idx", {60'h0, src_idx}, {60'h0, b[0], rm[2:0]});
      end
    end

    // R9 fault on a written base leaves it: GP write to GS after a good one
    @(negedge clk);
    pfx_rep = 1'b1; pfx_lock = 1'b0; rex_w = 1'b1; opc0 = 8'h0F; opc1 = 8'hAE;
    modrm = 8'hD8; cpu_mode = 3'd4; cr_fsgs_en = 1'b1; cap_fsgs = 1'b1;
    src_val = 64'h0000_1234_0000_5678; in_valid = 1'b1;
    @(negedge clk);
    src_val = 64'h00F0_0000_0000_0000;
    @(posedge clk); #1;
    chk(fault === 2'd2, "R8 GP after write", {62'h0, fault}, 64'd2);
    chk(gs_base === 64'h0000_1234_0000_5678, "R9 gs kept on fault", gs_base, 64'h0000_1234_0000_5678);
    @(negedge clk); in_valid = 1'b0;

    // R12 reset mid-run clears bases
    rst_n = 1'b0;
    #1;
    chk(fs_base === 64'h0 && gs_base === 64'h0, "R12 reset clears bases", fs_base | gs_base, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    report();
  end
endmodule